// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the raster timing for a TFT or STN display panel from a pixel clock. Software loads five timing words over a simple write port: the horizontal sync window, the vertical sync window, the frame total, the horizontal visible window and the vertical visible window. Each word packs two 16-bit positions. A horizontal counter walks across each line and a vertical counter steps once per line. Each counter returns to zero when it reaches its programmed total. The block derives horizontal sync, vertical sync and display-enable from the counter values and reports the current pixel position.

Sync pulses and the visible area are set by absolute positions inside the programmed total, not by chained porch and pulse widths. A TFT setup places both sync pulses ahead of the visible area. An STN setup places the line pulse after the visible pixels and anchors the visible frame at line 0. A serial mode spends three clocks on each pixel, one per colour channel, and reports which channel is being sent. Two sticky flags record frame start and frame end and drive a maskable interrupt. The controller has two ways to stop: a graceful stop that finishes the current frame, and an immediate stop.

Top module: `lcd_timing_gen`

## Requirements
- R1: A timing word holds its start position in bits 31:16 and its end position in bits 15:0. The `wr_sel` codes are: 0 line sync window, 1 frame sync window, 2 totals (horizontal total in the upper half, line count in the lower half), 3 horizontal visible window, 4 vertical visible window, 5 control, 6 status.
- R2: While running, `hpos` counts pixels from 0 to the horizontal total minus 1 and then wraps to 0. `vpos` steps on each wrap and runs from 0 to the vertical total minus 1. Both ports read 0 while stopped.
- R3: `hsync` is high exactly when `hpos` is at or above the line-sync start and below its end. `vsync` follows the same rule on `vpos` with the frame-sync window. A window may lie before or after the visible area.
- R4: `de` is high only when `hpos` lies inside the horizontal visible window and `vpos` lies inside the vertical visible window. Both windows have an exclusive end.
- R5: With control bit 0 set, each pixel lasts three clocks and `chan` steps 0, 1, 2 within it. With control bit 0 clear, each pixel lasts one clock and `chan` stays 0.
- R6: After reset the block is stopped and status bit 0 reads 1. A control write with bit 3 set and bit 4 clear starts the scan at (0,0) on the next clock and clears status bit 0.
- R7: A control write with bits 3 and 4 both set while running lets the current frame finish. The clock after the last pixel clock of that frame, the block is stopped, status bit 0 reads 1 and `dis_done` is high for exactly one clock.
- R8: A control write with bit 3 clear stops the block on the next clock. All outputs go to their idle values and `dis_done` stays low.
- R9: Status bit 4 is set one clock after the first pixel clock of a frame. Status bit 5 is set one clock after the last pixel clock of a frame.
- R10: A status write clears bit 4 or bit 5 where the written bit is 0 and leaves it unchanged where the written bit is 1. An event in the same clock keeps its flag set.
- R11: `irq` is high when status bit 4 is set and control bit 12 was last written as 1, or when status bit 5 is set and control bit 13 was last written as 1.
- R12: While running, new timing words and a new value of control bit 0 take effect from the next frame onwards. While stopped, they take effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code (R1) |
| wr_data | input | 32 | Write data |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Display enable |
| hpos | output | 16 | Horizontal pixel position |
| vpos | output | 16 | Line position |
| chan | output | 2 | Colour channel slot in serial mode |
| stat_word | output | 32 | Status: bit 0 stopped, bit 4 frame start, bit 5 frame end |
| irq | output | 1 | Interrupt request |
| dis_done | output | 1 | One-clock pulse when a graceful stop completes |

## Verification
The counter-range properties assume nonzero totals. They also assume that a total changes only at a frame wrap or while stopped, which the shadow registers enforce. A scan that starts with a zero total is left unchecked. Every test programs totals of 10 pixels by 6 lines, with all window ends at or below those totals. All timing words are written either while stopped or in the middle of a frame, at most one write per clock, so every frame-boundary check sees one stable configuration.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int unsigned FIELD_W = 16;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned SPAN_N  = 5;
    localparam int unsigned SEL_W   = 3;

    typedef logic [FIELD_W-1:0] pos_t;

    // start position in the upper half of a word, end in the lower half
    typedef struct packed {
        pos_t first;
        pos_t last;
    } span_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_HSYNC = 3'd0,
        SEL_VSYNC = 3'd1,
        SEL_TOTAL = 3'd2,
        SEL_HDISP = 3'd3,
        SEL_VDISP = 3'd4,
        SEL_CTRL  = 3'd5,
        SEL_STAT  = 3'd6,
        SEL_NONE  = 3'd7
    } sel_e;

    localparam int CB_SERIAL = 0;
    localparam int CB_RUN    = 3;
    localparam int CB_STOP   = 4;
    localparam int CB_SOF_IE = 12;
    localparam int CB_EOF_IE = 13;

    localparam int SB_OFF = 0;
    localparam int SB_SOF = 4;
    localparam int SB_EOF = 5;

    typedef struct packed {
        span_t hs;
        span_t vs;
        span_t tot;
        span_t hd;
        span_t vd;
        logic  serial;
    } timing_t;

    function automatic logic inside_span(pos_t p, span_t s);
        return (p >= s.first) && (p < s.last);
    endfunction

endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
    import lcdt_pkg::*;
#(
    parameter int unsigned SPANS = SPAN_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              load,
    output timing_t           act
);

    span_t [SPANS-1:0] shadow_q;
    span_t [SPANS-1:0] shadow_d;
    logic              ser_q;
    logic              ser_d;
    timing_t           act_d;

    always_comb begin
        for (int i = 0; i < SPANS; i++) begin
            shadow_d[i] = (wr_en && wr_sel == SEL_W'(i)) ? span_t'(wr_data) : shadow_q[i];
        end
        ser_d = (wr_en && wr_sel == SEL_CTRL) ? wr_data[CB_SERIAL] : ser_q;
    end

    // the pending value is used so a write in the loading cycle is not lost
    always_comb begin
        act_d.hs     = shadow_d[SEL_HSYNC];
        act_d.vs     = shadow_d[SEL_VSYNC];
        act_d.tot    = shadow_d[SEL_TOTAL];
        act_d.hd     = shadow_d[SEL_HDISP];
        act_d.vd     = shadow_d[SEL_VDISP];
        act_d.serial = ser_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            ser_q    <= 1'b0;
            act      <= '0;
        end else begin
            shadow_q <= shadow_d;
            ser_q    <= ser_d;
            if (load) act <= act_d;
        end
    end

endmodule

// File: rtl/lcdt_scan.sv
module lcdt_scan
    import lcdt_pkg::*;
#(
    parameter int unsigned PHASES = 3,
    localparam int unsigned PH_W  = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            serial,
    input  pos_t            htot,
    input  pos_t            vtot,
    output pos_t            h,
    output pos_t            v,
    output logic [PH_W-1:0] phase,
    output logic            frame_first,
    output logic            frame_last
);

    logic             tick;
    logic             h_last;
    logic             v_last;
    logic [FIELD_W:0] h_next;
    logic [FIELD_W:0] v_next;

    always_comb begin
        tick        = !serial || (phase == PH_W'(PHASES - 1));
        h_next      = {1'b0, h} + (FIELD_W+1)'(1);
        v_next      = {1'b0, v} + (FIELD_W+1)'(1);
        h_last      = h_next >= {1'b0, htot};
        v_last      = v_next >= {1'b0, vtot};
        frame_last  = run && tick && h_last && v_last;
        frame_first = run && (h == '0) && (v == '0) && (phase == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            h     <= '0;
            v     <= '0;
            phase <= '0;
        end else begin
            if (serial) phase <= tick ? '0 : phase + PH_W'(1);
            else        phase <= '0;
            if (tick) begin
                if (h_last) begin
                    h <= '0;
                    v <= v_last ? '0 : v_next[FIELD_W-1:0];
                end else begin
                    h <= h_next[FIELD_W-1:0];
                end
            end
        end
    end

    // R2: counters stay below their totals while scanning
    assert_hpos_in_total_R2: assert property (@(posedge clk) disable iff (rst)
        (run && htot != '0) |-> (h < htot));
    assert_vpos_in_total_R2: assert property (@(posedge clk) disable iff (rst)
        (run && vtot != '0) |-> (v < vtot));
    // R5: no channel stepping in parallel mode
    assert_phase_parallel_R5: assert property (@(posedge clk) disable iff (rst)
        (run && !serial) |-> (phase == '0));
    assert_phase_range_R5: assert property (@(posedge clk) disable iff (rst)
        phase <= PH_W'(PHASES - 1));

endmodule

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
    import lcdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              stat_wr,
    input  logic              wr_run,
    input  logic              wr_stop,
    input  logic              wr_sof_ie,
    input  logic              wr_eof_ie,
    input  logic              wr_sof_keep,
    input  logic              wr_eof_keep,
    input  logic              frame_first,
    input  logic              frame_last,
    output logic              run,
    output logic [WORD_W-1:0] stat_word,
    output logic              irq,
    output logic              dis_done
);

    logic pend_q;
    logic sof_q;
    logic eof_q;
    logic sof_ie_q;
    logic eof_ie_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            pend_q   <= 1'b0;
            dis_done <= 1'b0;
            sof_ie_q <= 1'b0;
            eof_ie_q <= 1'b0;
        end else begin
            dis_done <= 1'b0;
            if (ctrl_wr) begin
                sof_ie_q <= wr_sof_ie;
                eof_ie_q <= wr_eof_ie;
                if (!wr_run) begin
                    run    <= 1'b0;
                    pend_q <= 1'b0;
                end else if (!wr_stop) begin
                    run    <= 1'b1;
                    pend_q <= 1'b0;
                end else if (run) begin
                    pend_q <= 1'b1;
                end
            end else if (pend_q && frame_last) begin
                run      <= 1'b0;
                pend_q   <= 1'b0;
                dis_done <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sof_q <= 1'b0;
            eof_q <= 1'b0;
        end else begin
            sof_q <= frame_first || (sof_q && !(stat_wr && !wr_sof_keep));
            eof_q <= frame_last  || (eof_q && !(stat_wr && !wr_eof_keep));
        end
    end

    always_comb begin
        stat_word         = '0;
        stat_word[SB_OFF] = !run;
        stat_word[SB_SOF] = sof_q;
        stat_word[SB_EOF] = eof_q;
        irq = (sof_q && sof_ie_q) || (eof_q && eof_ie_q);
    end

    // R6: a start command runs the scan on the next clock
    assert_start_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_run && !wr_stop) |=> run);
    // R7: the completion pulse is single and the block is stopped with it
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        dis_done |=> !dis_done);
    assert_done_stopped_R7: assert property (@(posedge clk) disable iff (rst)
        dis_done |-> !run);
    // R8: an immediate stop takes hold next clock with no completion pulse
    assert_quick_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !wr_run) |=> (!run && !dis_done));

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
#(
    parameter int unsigned PHASES = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [2:0]                  wr_sel,
    input  logic [31:0]                 wr_data,
    output logic                        hsync,
    output logic                        vsync,
    output logic                        de,
    output logic [15:0]                 hpos,
    output logic [15:0]                 vpos,
    output logic [$clog2(PHASES)-1:0]   chan,
    output logic [31:0]                 stat_word,
    output logic                        irq,
    output logic                        dis_done
);

    localparam int unsigned PH_W = $clog2(PHASES);

    timing_t         act;
    logic            run;
    logic            load;
    logic            frame_first;
    logic            frame_last;
    pos_t            h;
    pos_t            v;
    logic [PH_W-1:0] phase;
    logic            ctrl_wr;
    logic            stat_wr;

    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign stat_wr = wr_en && (wr_sel == SEL_STAT);
    assign load    = !run || frame_last;

    lcdt_regs #(.SPANS(SPAN_N)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .load    (load),
        .act     (act)
    );

    lcdt_scan #(.PHASES(PHASES)) u_scan (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .serial      (act.serial),
        .htot        (act.tot.first),
        .vtot        (act.tot.last),
        .h           (h),
        .v           (v),
        .phase       (phase),
        .frame_first (frame_first),
        .frame_last  (frame_last)
    );

    lcdt_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ctrl_wr     (ctrl_wr),
        .stat_wr     (stat_wr),
        .wr_run      (wr_data[CB_RUN]),
        .wr_stop     (wr_data[CB_STOP]),
        .wr_sof_ie   (wr_data[CB_SOF_IE]),
        .wr_eof_ie   (wr_data[CB_EOF_IE]),
        .wr_sof_keep (wr_data[SB_SOF]),
        .wr_eof_keep (wr_data[SB_EOF]),
        .frame_first (frame_first),
        .frame_last  (frame_last),
        .run         (run),
        .stat_word   (stat_word),
        .irq         (irq),
        .dis_done    (dis_done)
    );

    always_comb begin
        hsync = run && inside_span(h, act.hs);
        vsync = run && inside_span(v, act.vs);
        de    = run && inside_span(h, act.hd) && inside_span(v, act.vd);
        hpos  = run ? h : '0;
        vpos  = run ? v : '0;
        chan  = run ? phase : '0;
    end

    // R9: the frame-start flag rises only after a clock at the scan origin
    assert_sof_origin_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_word[SB_SOF]) |-> $past(!stat_word[SB_OFF] && hpos == '0 && vpos == '0 && chan == '0));
    // R4: display enable never appears while stopped
    assert_de_running_R4: assert property (@(posedge clk) disable iff (rst)
        de |-> !stat_word[SB_OFF]);

endmodule

// File: tb/sim_lcd_timing_gen.sv
`timescale 1ns/1ps
module sim_lcd_timing_gen;

    localparam int HT = 10;
    localparam int VT = 6;
    localparam logic [31:0] C_RUN  = 32'h0000_0008;
    localparam logic [31:0] C_STOP = 32'h0000_0010;
    localparam logic [31:0] C_SER  = 32'h0000_0001;
    localparam logic [31:0] C_SOFE = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd7;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, de, irq, dis_done;
    logic [15:0] hpos, vpos;
    logic [1:0]  chan;
    logic [31:0] stat_word;

    int n_chk = 0;
    int n_fail = 0;
    int hs0 = 0, hs1 = 2, vs0 = 0, vs1 = 1, hd0 = 3, hd1 = 8, vd0 = 2, vd1 = 5;

    always #2.5 clk = ~clk;

    lcd_timing_gen u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .de(de), .hpos(hpos), .vpos(vpos),
        .chan(chan), .stat_word(stat_word), .irq(irq), .dis_done(dis_done)
    );

    function automatic logic [31:0] pk(int a, int b);
        return {a[15:0], b[15:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input int sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel[2:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 3'd7; wr_data = '0;
    endtask

    task automatic wait_pos(input int h, input int v, input string req);
        for (int i = 0; i < 2000; i++) begin
            step();
            if (hpos == h[15:0] && vpos == v[15:0]) return;
        end
        chk(1'b0, req, "position never reached", hpos, h);
    endtask

    task automatic check_pos(input int k, input bit ser);
        int pix = ser ? k / 3 : k;
        int h = pix % HT;
        int v = (pix / HT) % VT;
        int ch = ser ? k % 3 : 0;
        chk(hpos == h[15:0], "R2", "hpos", hpos, h);
        chk(vpos == v[15:0], "R2", "vpos", vpos, v);
        chk(chan == ch[1:0], "R5", "chan", chan, ch);
        chk(hsync == (h >= hs0 && h < hs1), "R1 R3", "hsync", hsync, int'(h >= hs0 && h < hs1));
        chk(vsync == (v >= vs0 && v < vs1), "R3", "vsync", vsync, int'(v >= vs0 && v < vs1));
        chk(de == (h >= hd0 && h < hd1 && v >= vd0 && v < vd1), "R4", "de", de,
            int'(h >= hd0 && h < hd1 && v >= vd0 && v < vd1));
    endtask

    task automatic t_reset();
        chk(stat_word[0] == 1'b1, "R6", "stopped after reset", stat_word[0], 1);
        chk(hsync == 0 && vsync == 0 && de == 0, "R6", "idle syncs", de, 0);
        chk(hpos == 0 && vpos == 0, "R2", "idle position", hpos, 0);
        chk(stat_word[5:4] == 2'b00 && irq == 0, "R9", "flags after reset", stat_word[5:4], 0);
    endtask

    task automatic t_parallel();
        wr(0, pk(hs0, hs1)); wr(1, pk(vs0, vs1)); wr(2, pk(HT, VT));
        wr(3, pk(hd0, hd1)); wr(4, pk(vd0, vd1));
        chk(stat_word[0] == 1'b1, "R6", "no start without command", stat_word[0], 1);
        wr(5, C_RUN);
        chk(stat_word[0] == 1'b0, "R6", "running after start", stat_word[0], 0);
        for (int k = 0; k < 2 * HT * VT; k++) begin
            check_pos(k, 1'b0);
            step();
        end
        chk(stat_word[4] == 1'b1, "R9", "start flag seen", stat_word[4], 1);
        chk(stat_word[5] == 1'b1, "R9", "end flag seen", stat_word[5], 1);
        chk(irq == 1'b0, "R11", "masked irq", irq, 0);
    endtask

    task automatic t_flags();
        wait_pos(5, 2, "R10");
        wr(6, 32'h0);
        chk(stat_word[5:4] == 2'b00, "R10", "flags cleared", stat_word[5:4], 0);
        wr(5, C_RUN | C_SOFE);
        wait_pos(0, 0, "R9");
        chk(stat_word[5] == 1'b1, "R9", "end flag at wrap", stat_word[5], 1);
        chk(stat_word[4] == 1'b0, "R9", "start flag not yet", stat_word[4], 0);
        chk(irq == 1'b0, "R11", "end flag masked", irq, 0);
        step();
        chk(stat_word[4] == 1'b1, "R9", "start flag set", stat_word[4], 1);
        chk(irq == 1'b1, "R11", "start irq", irq, 1);
        wr(6, 32'h30);
        chk(stat_word[5:4] == 2'b11, "R10", "write ones keeps flags", stat_word[5:4], 3);
        wr(6, 32'h0);
        chk(stat_word[5:4] == 2'b00, "R10", "write zeros clears", stat_word[5:4], 0);
        chk(irq == 1'b0, "R11", "irq drops with flag", irq, 0);
    endtask

    task automatic t_shadow();
        wait_pos(2, 3, "R12");
        wr(3, pk(1, 4));
        wait_pos(6, 3, "R12");
        chk(de == 1'b1, "R12", "old window this frame", de, 1);
        wait_pos(2, 3, "R12");
        chk(de == 1'b1, "R12", "new window inside", de, 1);
        wait_pos(6, 3, "R12");
        chk(de == 1'b0, "R12", "new window outside", de, 0);
        wr(3, pk(3, 8));
    endtask

    task automatic t_graceful();
        wait_pos(5, 2, "R7");
        wr(5, C_RUN | C_STOP | C_SOFE);
        chk(stat_word[0] == 1'b0, "R7", "still running after request", stat_word[0], 0);
        wait_pos(HT - 1, VT - 1, "R7");
        chk(stat_word[0] == 1'b0 && dis_done == 1'b0, "R7", "running on last pixel", stat_word[0], 0);
        step();
        chk(stat_word[0] == 1'b1, "R7", "stopped after frame", stat_word[0], 1);
        chk(dis_done == 1'b1, "R7", "done pulse", dis_done, 1);
        chk(de == 0 && hsync == 0 && hpos == 0, "R7", "idle outputs", hpos, 0);
        step();
        chk(dis_done == 1'b0, "R7", "done pulse one clock", dis_done, 0);
    endtask

    task automatic t_serial();
        hs0 = 8; hs1 = 10;
        wr(0, pk(hs0, hs1));
        wr(5, C_RUN | C_SER);
        for (int k = 0; k < 3 * HT * VT; k++) begin
            check_pos(k, 1'b1);
            step();
        end
    endtask

    task automatic t_quick();
        wait_pos(5, 2, "R8");
        wr(5, 32'h0);
        chk(stat_word[0] == 1'b1, "R8", "stopped next clock", stat_word[0], 1);
        chk(de == 0 && hsync == 0 && vsync == 0, "R8", "idle syncs", de, 0);
        chk(hpos == 0 && vpos == 0 && chan == 0, "R8", "idle position", hpos, 0);
        chk(dis_done == 1'b0, "R8", "no done pulse", dis_done, 0);
        step(); step();
        chk(stat_word[0] == 1'b1 && dis_done == 1'b0, "R8", "stays stopped", stat_word[0], 1);
    endtask

    initial begin
        #(5.0 * 200000);
        chk(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_parallel();
        t_flags();
        t_shadow();
        t_graceful();
        t_serial();
        t_quick();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule